// File: doc/BRIEF.md
# Reset Qualifier and Boot-Mode Selector

This block sits between the external reset and program-store-enable pins and the rest of the chip. It brings both pins into the clock domain through two-flop synchronizers. It counts machine-cycle ticks while the reset pin is high. It holds the core in reset only once the pin has been high for two machine cycles, so a shorter glitch does nothing.

While the reset pin stays high, the block also watches the program-store-enable pin for a forced high-to-low transition. When the reset pin is released, the block picks one of two boot modes:

- **Host programming mode:** chosen when such a transition was seen during the high interval and more than ten machine cycles were counted.
- **Normal operation:** chosen in every other case.

The choice is latched at release. It does not change until the next qualified reset.

The machine-cycle tick comes from the clock generator. It pulses once every 12 oscillator clocks in standard mode and once every 6 in double-speed mode. The block does not depend on which rate is selected.

Top module: `rst_boot_qual`

## Requirements
- R1: After the asynchronous block reset, the outputs are core_rst=0, host_mode=0 and normal_mode=1.
- R2: core_rst rises once the synchronized reset pin has been high while at least two machine-cycle ticks were counted. It falls on the second clock edge after the pin is seen low at the synchronizer input.
- R3: A reset-pin pulse covering fewer than two ticks does not raise core_rst and leaves the mode flags unchanged.
- R4: While core_rst is 1, host_mode and normal_mode are both 0.
- R5: At release, host_mode=1 and normal_mode=0 if both of the following held during the high interval: a falling edge of the synchronized program-store-enable pin was seen, and more than 10 ticks were counted.
- R6: A program-store-enable falling edge during a qualified reset of 10 or fewer ticks gives normal_mode=1 and host_mode=0 at release.
- R7: A qualified reset with no program-store-enable falling edge gives normal_mode=1 and host_mode=0 at release.
- R8: A low level on the synchronized reset pin clears the tick counter and any captured program-store-enable edge. Ticks and edges from an earlier high interval do not count toward a later one.
- R9: Outside a qualified reset, the mode flags hold their value, and program-store-enable activity has no effect on them.
- R10: The tick counter saturates at its all-ones value (15 by default), so a reset held for any length still selects host mode when an edge was seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived block clock |
| arst_n | input | 1 | Asynchronous active-low block reset (power-on) |
| mc_tick | input | 1 | One-clock pulse per machine cycle (every 12 or 6 clocks) |
| rst_pin | input | 1 | Raw external reset pin, active high |
| psen_pin | input | 1 | Raw program-store-enable pin |
| core_rst | output | 1 | Qualified internal reset, active high |
| host_mode | output | 1 | Device leaves reset in external host programming mode |
| normal_mode | output | 1 | Device leaves reset in normal operation |

## Verification
The assertions assume that the machine-cycle tick is at most one clock wide and is spaced at least three clocks apart. They also assume that both pins are held stable between clock edges. Under these assumptions, each tick falls cleanly inside or outside a synchronized reset interval.

The stimulus respects these assumptions:
- It generates the tick at periods of 6 and 3 clocks.
- It changes the pins only on falling clock edges.
- It drops the reset pin right after a tick, so the count in the design equals the count in the stimulus.
- It places program-store-enable edges only inside the high interval, or after release when checking R9.

// File: rtl/rbq_pkg.sv
package rbq_pkg;
  typedef enum logic [1:0] {
    BOOT_UNDECIDED = 2'b00,
    BOOT_NORMAL    = 2'b01,
    BOOT_HOST      = 2'b10
  } boot_mode_e;
endpackage

// File: rtl/rbq_sync.sv
module rbq_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;
      always_comb begin
        chain_d = {chain_q[STAGES-2:0], d[b]};
      end
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= chain_d;
      end
      assign q[b] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/rbq_cyc_cnt.sv
module rbq_cyc_cnt #(
  parameter int CNT_W    = 4,
  parameter int RST_QUAL = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             rst_s,
  input  logic             mc_tick,
  output logic [CNT_W-1:0] cnt,
  output logic             qual
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] QUAL_C  = CNT_W'(RST_QUAL);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = rst_s & mc_tick & (cnt_q != CNT_MAX);
    if (!rst_s)      cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign qual = rst_s & (cnt_q >= QUAL_C);
endmodule

// File: rtl/rbq_boot_decide.sv
module rbq_boot_decide
  import rbq_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int HOST_MIN = 10
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             rst_s,
  input  logic             psen_s,
  input  logic             qual,
  input  logic [CNT_W-1:0] cnt,
  output logic             core_rst,
  output logic             host_mode,
  output logic             normal_mode
);
  localparam logic [CNT_W-1:0] HOST_MIN_C = CNT_W'(HOST_MIN);

  logic       psen_d_q;
  logic       seen_q, seen_d;
  logic       crst_q, crst_d;
  boot_mode_e mode_q, mode_d;
  logic       psen_fall, release_ev;

  always_comb begin
    psen_fall  = psen_d_q & ~psen_s;
    release_ev = crst_q & ~rst_s;
    seen_d     = rst_s ? (seen_q | psen_fall) : 1'b0;
    crst_d     = qual;
    if (qual)
      mode_d = BOOT_UNDECIDED;
    else if (release_ev)
      mode_d = (seen_q && (cnt > HOST_MIN_C)) ? BOOT_HOST : BOOT_NORMAL;
    else
      mode_d = mode_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      psen_d_q <= 1'b0;
      seen_q   <= 1'b0;
      crst_q   <= 1'b0;
      mode_q   <= BOOT_NORMAL;
    end else begin
      psen_d_q <= psen_s;
      seen_q   <= seen_d;
      crst_q   <= crst_d;
      mode_q   <= mode_d;
    end
  end

  assign core_rst    = crst_q;
  assign host_mode   = (mode_q == BOOT_HOST);
  assign normal_mode = (mode_q == BOOT_NORMAL);
endmodule

// File: rtl/rst_boot_qual.sv
module rst_boot_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4,
  parameter int RST_QUAL    = 2,
  parameter int HOST_MIN    = 10
) (
  input  logic clk,
  input  logic arst_n,
  input  logic mc_tick,
  input  logic rst_pin,
  input  logic psen_pin,
  output logic core_rst,
  output logic host_mode,
  output logic normal_mode
);
  logic [1:0]       pins_s;
  logic             rst_s, psen_s, qual;
  logic [CNT_W-1:0] cyc_cnt;

  rbq_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk(clk), .arst_n(arst_n), .d({psen_pin, rst_pin}), .q(pins_s)
  );
  assign rst_s  = pins_s[0];
  assign psen_s = pins_s[1];

  rbq_cyc_cnt #(.CNT_W(CNT_W), .RST_QUAL(RST_QUAL)) u_cnt (
    .clk(clk), .arst_n(arst_n), .rst_s(rst_s), .mc_tick(mc_tick),
    .cnt(cyc_cnt), .qual(qual)
  );

  rbq_boot_decide #(.CNT_W(CNT_W), .HOST_MIN(HOST_MIN)) u_dec (
    .clk(clk), .arst_n(arst_n), .rst_s(rst_s), .psen_s(psen_s),
    .qual(qual), .cnt(cyc_cnt), .core_rst(core_rst),
    .host_mode(host_mode), .normal_mode(normal_mode)
  );
endmodule

// File: rtl/rbq_chk.sv
module rbq_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             arst_n,
  input logic             rst_pin,
  input logic             rst_s,
  input logic [CNT_W-1:0] cnt,
  input logic             core_rst,
  input logic             host_mode,
  input logic             normal_mode
);
  // R2
  rise_needs_pin_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(core_rst) |-> $past(rst_pin, 3) && ($past(cnt) >= 2));
  // R4
  flags_clear_in_rst_chk: assert property (@(posedge clk) disable iff (!arst_n)
    core_rst |-> !host_mode && !normal_mode);
  // R7
  one_mode_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !core_rst |-> $countones({host_mode, normal_mode}) == 1);
  // R5
  host_at_release_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(host_mode) |-> $fell(core_rst));
  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!core_rst && !$past(core_rst)) |-> $stable(host_mode) && $stable(normal_mode));
  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !$past(rst_s) |-> cnt == '0);
  // R10
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (rst_s && $past(rst_s)) |-> cnt >= $past(cnt));
endmodule

bind rst_boot_qual rbq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .arst_n(arst_n), .rst_pin(rst_pin), .rst_s(rst_s),
  .cnt(cyc_cnt), .core_rst(core_rst), .host_mode(host_mode),
  .normal_mode(normal_mode)
);

// File: tb/rst_boot_qual_bench.sv
`timescale 1ns/1ps
module rst_boot_qual_bench;
  logic clk, arst_n, mc_tick, rst_pin, psen_pin;
  logic core_rst, host_mode, normal_mode;
  int   n_cmp, n_bad, tick_div, tick_ctr;
  bit   cmp_en, saw_crst, saw_flag_in_rst;

  rst_boot_qual u_rst_boot_qual (
    .clk(clk), .arst_n(arst_n), .mc_tick(mc_tick), .rst_pin(rst_pin),
    .psen_pin(psen_pin), .core_rst(core_rst), .host_mode(host_mode),
    .normal_mode(normal_mode)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (!arst_n) begin tick_ctr <= 0; mc_tick <= 1'b0; end
    else begin
      tick_ctr <= (tick_ctr + 1 >= tick_div) ? 0 : tick_ctr + 1;
      mc_tick  <= (tick_ctr == 0);
    end
  end

  // behavioural reference
  int m_rs1, m_rs2, m_ps1, m_ps2, m_pd, m_cnt, m_seen, m_crst, m_host, m_norm;
  always @(posedge clk or negedge arst_n) begin : model
    int fall, q;
    if (!arst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_ps1 = 0; m_ps2 = 0; m_pd = 0;
      m_cnt = 0; m_seen = 0; m_crst = 0; m_host = 0; m_norm = 1;
    end else begin
      fall = (m_pd == 1 && m_ps2 == 0) ? 1 : 0;
      if (m_rs2 == 1) begin
        q = (m_cnt >= 2) ? 1 : 0;
        if (mc_tick && m_cnt < 15) m_cnt = m_cnt + 1;
        m_crst = q;
        if (q == 1) begin m_host = 0; m_norm = 0; end
        if (fall == 1) m_seen = 1;
      end else begin
        if (m_crst == 1) begin
          m_host = (m_seen == 1 && m_cnt > 10) ? 1 : 0;
          m_norm = 1 - m_host;
        end
        m_crst = 0; m_cnt = 0; m_seen = 0;
      end
      m_pd = m_ps2; m_ps2 = m_ps1; m_ps1 = psen_pin;
      m_rs2 = m_rs1; m_rs1 = rst_pin;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (cmp_en) begin
      check("R2 core_rst vs model", core_rst, m_crst);
      check("R5 host_mode vs model", host_mode, m_host);
      check("R7 normal_mode vs model", normal_mode, m_norm);
      if (core_rst) saw_crst = 1'b1;
      if (core_rst && (host_mode || normal_mode)) saw_flag_in_rst = 1'b1;
    end
  end

  // hold reset for n counted ticks; psen falls after tick fall_at (0 = never)
  task automatic hold_rst(input int n, input int fall_at);
    int k;
    saw_crst = 1'b0; saw_flag_in_rst = 1'b0;
    @(negedge clk) rst_pin = 1'b1;
    repeat (3) @(posedge clk);
    k = 0;
    while (k < n) begin
      @(posedge clk);
      if (mc_tick) begin
        k++;
        if (k == fall_at && k < n) @(negedge clk) psen_pin = 1'b0;
      end
    end
    @(negedge clk) begin rst_pin = 1'b0; psen_pin = 1'b1; end
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0; cmp_en = 1'b0; tick_div = 6;
    rst_pin = 1'b0; psen_pin = 1'b1; arst_n = 1'b0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1; cmp_en = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check("R1 core_rst after block reset", core_rst, 0);
    check("R1 host_mode after block reset", host_mode, 0);
    check("R1 normal_mode after block reset", normal_mode, 1);
    // R3: one tick only
    hold_rst(1, 0);
    check("R3 short pulse no core_rst", saw_crst, 0);
    check("R3 short pulse normal kept", normal_mode, 1);
    // R2, R4, R7
    hold_rst(5, 0);
    check("R2 core_rst seen", saw_crst, 1);
    check("R2 core_rst released", core_rst, 0);
    check("R4 flags low in reset", saw_flag_in_rst, 0);
    check("R7 normal without edge", normal_mode, 1);
    // R5
    hold_rst(11, 4);
    check("R5 host selected", host_mode, 1);
    check("R5 normal cleared", normal_mode, 0);
    // R9: psen toggles after release
    repeat (3) begin
      @(negedge clk) psen_pin = 1'b0;
      repeat (4) @(negedge clk);
      psen_pin = 1'b1;
      repeat (4) @(negedge clk);
    end
    check("R9 host held", host_mode, 1);
    // R6
    hold_rst(9, 3);
    check("R6 short hold normal", normal_mode, 1);
    check("R6 short hold no host", host_mode, 0);
    // R8: counter cleared by a gap
    hold_rst(6, 0);
    hold_rst(6, 2);
    check("R8 count restarts", normal_mode, 1);
    // R8: capture cleared by a gap
    hold_rst(12, 3);
    hold_rst(12, 0);
    check("R8 capture restarts", normal_mode, 1);
    // R10: long hold in 6-clock mode
    tick_div = 3;
    repeat (4) @(negedge clk);
    hold_rst(40, 20);
    check("R10 saturated host", host_mode, 1);
    hold_rst(40, 0);
    check("R10 saturated normal", normal_mode, 1);
    repeat (5) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule